// File: doc/BRIEF.md
# Serial Avionics Word Receiver with Split Host Readout

This block rebuilds 32-bit words from a two-wire return-to-zero avionics line that has already been level-detected. One wire is high during a "one" pulse and the other is high during a "zero" pulse. Both low is the null level that separates bits. The line is sampled ten times per bit. The sample tick is the block clock itself for the fast rate, or the clock divided by eight for the slow rate. Every bit must show a pulse of about half a bit followed by a null of about half a bit. Any sample or phase outside those shapes discards the word in flight. A long null acts as the word gap and re-arms the receiver.

A complete word may be screened on two of its label bits. Its last bit is replaced by a parity verdict before it is stored. A host reads the stored word as two 16-bit halves, chosen by a select input and taken with a one-cycle read strobe. An active-low ready flag tells the host that a word is waiting. The flag stays low until both halves have been taken, in either order. A newer word replaces an unread one. For self test, a loopback input swaps the line wires for the local transmitter's ones/zeros wires.

Top module: `a429_word_rx`

## Requirements
- R1: A sample is taken every clock when `rate_slow` is 0, and once every 8 clocks when it is 1. A nominal bit is 10 samples: 5 pulse samples followed by 5 null samples. Stimulus timed for the fast rate and received at the slow rate yields no word.
- R2: The first serial bit is word bit 1, stored at held index 0. Bit k is stored at index k-1. A word is complete when the null after the 32nd pulse is sampled.
- R3: When `label_chk_en` is 1, a complete word is stored only if word bit 9 equals `label_bits[0]` and word bit 10 equals `label_bits[1]`. When it is 0, every complete word is stored.
- R4: The stored bit 32 is 0 when the count of ones over all 32 received bits is odd, and 1 when the count is even.
- R5: After reset `ready_n` is 1. A stored word drives `ready_n` to 0.
- R6: A read is a one-cycle `rd_en` pulse. `ready_n` returns to 1 only once both halves have been read since the word was stored, in either order. Reading a single half, even repeatedly, keeps it at 0.
- R7: `rd_data` shows half 1 when `half_sel` is 0 and half 2 when it is 1. Half 1, from bit 15 down to bit 0, is word bits 13,12,11,10,9,31,30,32,1,2,3,4,5,6,7,8. Half 2 is word bits 29 down to 14.
- R8: A newly stored word overwrites an unread one. A read that lands in the same cycle as a store is void, and both halves must be read again.
- R9: The word in flight is discarded on any of these: a sample with both wires high; a pulse that changes polarity without a null; a pulse shorter than 4 or longer than 6 samples; or a null between two bits of a word shorter than 4 or longer than 6 samples. Pulses of 4 or 6 samples and nulls of 4 or 6 samples are accepted.
- R10: A word can begin only after 30 consecutive null samples. That many nulls in the middle of a word abort it. After a stored or discarded word, a pulse arriving before such a gap is ignored.
- R11: When `loopback_en` is 1, the receiver takes `tx_one`/`tx_zero` and ignores `line_one`/`line_zero`. When it is 0, the reverse holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rate_slow | input | 1 | 0: sample every clock; 1: sample every 8 clocks |
| loopback_en | input | 1 | 1 selects the transmitter wires as receiver input |
| line_one | input | 1 | Line detector, high during a one pulse |
| line_zero | input | 1 | Line detector, high during a zero pulse |
| tx_one | input | 1 | Local transmitter ones wire |
| tx_zero | input | 1 | Local transmitter zeros wire |
| label_chk_en | input | 1 | Enables the bit 9/10 screen |
| label_bits | input | 2 | Required values: [0] for bit 9, [1] for bit 10 |
| rd_en | input | 1 | Read strobe, one cycle per half |
| half_sel | input | 1 | 0: half 1, 1: half 2 |
| rd_data | output | 16 | Selected half of the stored word |
| ready_n | output | 1 | Low while a stored word is not fully read |

## Verification
The store of a completed word and a host read strobe can fall in the same clock. The bench times a read pulse to the cycle right after the null that ends bit 32 is sampled, while an older word is still unread. It then reads only the other half and checks that `ready_n` is still low, so the colliding read must have been voided. A final read of the second half releases the flag, and the data must come from the newer word.

// File: rtl/a429_rx_pkg.sv
package a429_rx_pkg;

  localparam int WORD_BITS = 32;

  // Detector pair encoded as {one, zero}
  localparam logic [1:0] SMP_NULL = 2'b00;
  localparam logic [1:0] SMP_ZERO = 2'b01;
  localparam logic [1:0] SMP_ONE  = 2'b10;
  localparam logic [1:0] SMP_BAD  = 2'b11;

  // 0 when the 32 received bits hold an odd number of ones
  function automatic logic parity_verdict(input logic [31:0] w);
    return ~(^w);
  endfunction

  function automatic logic label_ok(input logic en, input logic [1:0] want,
                                    input logic [31:0] w);
    return !en || (w[9:8] == want);
  endfunction

  // held index k carries word bit k+1
  function automatic logic [15:0] upper_view(input logic [31:0] h);
    logic [15:0] r;
    for (int k = 0; k < 8; k++) r[7-k] = h[k];
    r[8]  = h[31];
    r[9]  = h[29];
    r[10] = h[30];
    for (int k = 0; k < 5; k++) r[11+k] = h[8+k];
    return r;
  endfunction

  function automatic logic [15:0] lower_view(input logic [31:0] h);
    return h[28:13];
  endfunction

endpackage

// File: rtl/a429_sample_tick.sv
module a429_sample_tick #(
  parameter int FAST_DIV = 1,
  parameter int SLOW_DIV = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rate_slow,
  output logic tick
);
  localparam int MAXD = (FAST_DIV > SLOW_DIV) ? FAST_DIV : SLOW_DIV;
  localparam int CW = $clog2(MAXD + 1);
  localparam logic [CW-1:0] FAST_LIM = CW'(FAST_DIV - 1);
  localparam logic [CW-1:0] SLOW_LIM = CW'(SLOW_DIV - 1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] lim;

  assign lim  = rate_slow ? SLOW_LIM : FAST_LIM;
  assign tick = (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (cnt >= lim) cnt <= '0;
    else                 cnt <= cnt + 1'b1;
  end

  generate
    if (SLOW_DIV > 1) begin : g_chk
      assert_slow_spacing_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (rate_slow && tick) |=> !tick);
    end
  endgenerate

endmodule

// File: rtl/a429_bit_framer.sv
module a429_bit_framer
  import a429_rx_pkg::*;
#(
  parameter int SPB = 10
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick,
  input  logic [1:0]  smp,
  output logic        eos,
  output logic        err,
  output logic        gap_to,
  output logic [31:0] word
);
  localparam int NOM  = SPB / 2;
  localparam int GAP  = 3 * SPB;
  localparam int HW   = $clog2(SPB + 2);
  localparam int NW   = $clog2(GAP + 1);
  localparam int BW   = $clog2(WORD_BITS);
  localparam logic [HW-1:0] PH_MIN  = HW'(NOM - 1);
  localparam logic [HW-1:0] PH_MAX  = HW'(NOM + 1);
  localparam logic [NW-1:0] NU_MIN  = NW'(NOM - 1);
  localparam logic [NW-1:0] NU_MAX  = NW'(NOM + 1);
  localparam logic [NW-1:0] GAP_C   = NW'(GAP);
  localparam logic [NW-1:0] GAP_M1  = NW'(GAP - 1);
  localparam logic [BW-1:0] LAST_BIT = BW'(WORD_BITS - 1);

  logic          prev_high, lvl, armed;
  logic [HW-1:0] hi_cnt;
  logic [NW-1:0] null_cnt;
  logic [BW-1:0] bit_cnt;
  logic [31:0]   sr;

  // named events
  logic is_hi, is_null, v;
  logic f_both, f_swap, f_long, f_space, f_short, fault;
  logic bit_start, bit_done, last_bit, gap_hit;

  always_comb begin
    is_hi    = (smp == SMP_ONE) || (smp == SMP_ZERO);
    is_null  = (smp == SMP_NULL);
    v        = (smp == SMP_ONE);
    f_both   = tick && (smp == SMP_BAD);
    f_swap   = tick && is_hi && prev_high && armed && (v != lvl);
    f_long   = tick && is_hi && prev_high && armed && (v == lvl) && (hi_cnt >= PH_MAX);
    f_space  = tick && is_hi && !prev_high && armed && (bit_cnt != '0) &&
               ((null_cnt < NU_MIN) || (null_cnt > NU_MAX));
    f_short  = tick && is_null && prev_high && armed && (hi_cnt < PH_MIN);
    fault    = f_both || f_swap || f_long || f_space || f_short;
    bit_start = tick && is_hi && !prev_high && armed && !f_space;
    bit_done  = tick && is_null && prev_high && armed && !f_short;
    last_bit  = bit_done && (bit_cnt == LAST_BIT);
    gap_hit   = tick && is_null && !prev_high && (null_cnt == GAP_M1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_high <= 1'b0;
      lvl       <= 1'b0;
      armed     <= 1'b0;
      hi_cnt    <= '0;
      null_cnt  <= '0;
      bit_cnt   <= '0;
      sr        <= '0;
      eos       <= 1'b0;
      err       <= 1'b0;
      gap_to    <= 1'b0;
    end else begin
      eos    <= 1'b0;
      err    <= 1'b0;
      gap_to <= 1'b0;
      if (fault) begin
        err       <= 1'b1;
        armed     <= 1'b0;
        bit_cnt   <= '0;
        hi_cnt    <= '0;
        prev_high <= is_hi;
        null_cnt  <= is_hi ? '0 : NW'(1);
      end else if (tick) begin
        if (is_hi) begin
          prev_high <= 1'b1;
          null_cnt  <= '0;
          if (bit_start) begin
            lvl    <= v;
            hi_cnt <= HW'(1);
          end else if (prev_high && armed) begin
            hi_cnt <= hi_cnt + 1'b1;
          end
        end else begin
          prev_high <= 1'b0;
          if (prev_high)            null_cnt <= NW'(1);
          else if (null_cnt < GAP_C) null_cnt <= null_cnt + 1'b1;
          if (bit_done) begin
            sr <= {lvl, sr[31:1]};
            if (last_bit) begin
              bit_cnt <= '0;
              armed   <= 1'b0;
              eos     <= 1'b1;
            end else begin
              bit_cnt <= bit_cnt + 1'b1;
            end
          end
          if (gap_hit) begin
            armed   <= 1'b1;
            bit_cnt <= '0;
            if (bit_cnt != '0) gap_to <= 1'b1;
          end
        end
      end
    end
  end

  assign word = sr;

  assert_eos_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    eos |=> !eos);
  assert_fault_no_eos_R9: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> !eos);
  assert_abort_no_eos_R10: assert property (@(posedge clk) disable iff (!rst_n)
    gap_to |-> !eos);

endmodule

// File: rtl/a429_word_hold.sv
module a429_word_hold
  import a429_rx_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        eos,
  input  logic [31:0] word,
  input  logic        label_chk_en,
  input  logic [1:0]  label_bits,
  input  logic        rd_en,
  input  logic        half_sel,
  output logic [15:0] rd_data,
  output logic        ready_n
);
  logic [31:0] held;
  logic        got_up, got_lo, nxt_up, nxt_lo;
  logic        accept;

  assign accept = eos && label_ok(label_chk_en, label_bits, word);
  assign nxt_up = got_up || !half_sel;
  assign nxt_lo = got_lo || half_sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held    <= '0;
      got_up  <= 1'b0;
      got_lo  <= 1'b0;
      ready_n <= 1'b1;
    end else if (accept) begin
      held    <= {parity_verdict(word), word[30:0]};
      got_up  <= 1'b0;
      got_lo  <= 1'b0;
      ready_n <= 1'b0;
    end else if (rd_en && !ready_n) begin
      got_up <= nxt_up;
      got_lo <= nxt_lo;
      if (nxt_up && nxt_lo) ready_n <= 1'b1;
    end
  end

  assign rd_data = half_sel ? lower_view(held) : upper_view(held);

  assert_store_sets_ready_R5: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !ready_n);
  assert_label_reject_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (eos && !accept && ready_n) |=> ready_n);
  assert_release_by_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready_n) |-> $past(rd_en));
  assert_collide_void_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && rd_en) |=> !ready_n);

endmodule

// File: rtl/a429_word_rx.sv
module a429_word_rx
  import a429_rx_pkg::*;
#(
  parameter int SPB      = 10,
  parameter int FAST_DIV = 1,
  parameter int SLOW_DIV = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rate_slow,
  input  logic        loopback_en,
  input  logic        line_one,
  input  logic        line_zero,
  input  logic        tx_one,
  input  logic        tx_zero,
  input  logic        label_chk_en,
  input  logic [1:0]  label_bits,
  input  logic        rd_en,
  input  logic        half_sel,
  output logic [15:0] rd_data,
  output logic        ready_n
);
  logic        tick, eos, err, gap_to;
  logic [1:0]  smp;
  logic [31:0] word;

  assign smp = loopback_en ? {tx_one, tx_zero} : {line_one, line_zero};

  a429_sample_tick #(.FAST_DIV(FAST_DIV), .SLOW_DIV(SLOW_DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .rate_slow(rate_slow), .tick(tick)
  );

  a429_bit_framer #(.SPB(SPB)) u_framer (
    .clk(clk), .rst_n(rst_n), .tick(tick), .smp(smp),
    .eos(eos), .err(err), .gap_to(gap_to), .word(word)
  );

  a429_word_hold u_hold (
    .clk(clk), .rst_n(rst_n), .eos(eos), .word(word),
    .label_chk_en(label_chk_en), .label_bits(label_bits),
    .rd_en(rd_en), .half_sel(half_sel), .rd_data(rd_data), .ready_n(ready_n)
  );

  assert_eos_not_with_fault_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(eos && err));

endmodule

// File: tb/tb_a429_word_rx.sv
`timescale 1ns/1ps
module tb_a429_word_rx;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n = 1'b0, rate_slow = 1'b0, loopback_en = 1'b0;
  logic line_one = 1'b0, line_zero = 1'b0, tx_one = 1'b0, tx_zero = 1'b0;
  logic label_chk_en = 1'b0, rd_en = 1'b0, half_sel = 1'b0;
  logic [1:0] label_bits = 2'b00;
  logic [15:0] rd_data;
  logic ready_n;

  a429_word_rx dut (
    .clk(clk), .rst_n(rst_n), .rate_slow(rate_slow), .loopback_en(loopback_en),
    .line_one(line_one), .line_zero(line_zero), .tx_one(tx_one), .tx_zero(tx_zero),
    .label_chk_en(label_chk_en), .label_bits(label_bits), .rd_en(rd_en),
    .half_sel(half_sel), .rd_data(rd_data), .ready_n(ready_n)
  );

  int checks = 0, errors = 0, div = 1;
  bit lb = 1'b0, done = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  // drive one sample for div clocks; unused wire pair held at both-high
  task automatic put(input bit o, input bit z);
    if (lb) begin tx_one = o; tx_zero = z; line_one = 1; line_zero = 1; end
    else    begin line_one = o; line_zero = z; tx_one = 1; tx_zero = 1; end
    repeat (div) @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) put(0, 0);
  endtask

  // kind: 0 clean, 1 both-high, 2 polarity swap, 3 pulse 3, 4 pulse 7, 5 null 7
  task automatic send(input logic [31:0] w, input int hi, input int nu, input int kind,
                      input int at, input int coll, input int gap);
    for (int i = 0; i < 32; i++) begin
      bit b;
      int hl, nl;
      b = w[i]; hl = hi; nl = nu;
      if (kind == 3 && i == at) hl = 3;
      if (kind == 4 && i == at) hl = 7;
      if (kind == 5 && i == at) nl = 7;
      for (int j = 0; j < hl; j++) begin
        if (kind == 1 && i == at && j == 2) put(1, 1);
        else if (kind == 2 && i == at && j >= 2) put(!b, b);
        else put(b, !b);
      end
      for (int j = 0; j < nl; j++) begin
        if (coll >= 0 && i == 31 && j == 1) begin half_sel = coll[0]; rd_en = 1; end
        if (i == 31 && j == 2) rd_en = 0;
        put(0, 0);
      end
    end
    idle(gap);
  endtask

  task automatic rd(input bit sel, output logic [15:0] d);
    half_sel = sel;
    #1 d = rd_data;
    rd_en = 1;
    @(negedge clk);
    rd_en = 0;
  endtask

  function automatic logic pbit(input logic [31:0] w);
    int c = 0;
    for (int k = 0; k < 32; k++) c += w[k];
    return (c % 2 == 1) ? 1'b0 : 1'b1;
  endfunction

  function automatic logic [15:0] exp_up(input logic [31:0] w);
    logic [15:0] r;
    // bits 0..7 = word bits 8..1, bits 11..15 = word bits 9..13
    for (int b = 0; b < 8; b++) r[b] = w[7-b];
    for (int b = 11; b < 16; b++) r[b] = w[b-3];
    r[8] = pbit(w); r[9] = w[29]; r[10] = w[30];
    return r;
  endfunction

  task automatic take_word(input logic [31:0] w, input bit lo_first, input string req);
    logic [15:0] d1, d2;
    chk(ready_n == 0, req, "ready before read", {31'b0, ready_n}, 0);
    rd(lo_first, d1);
    chk(ready_n == 0, "R6", "ready after one half", {31'b0, ready_n}, 0);
    rd(!lo_first, d2);
    chk(ready_n == 1, "R6", "ready after both halves", {31'b0, ready_n}, 1);
    if (lo_first) begin
      chk(d1 == w[28:13], "R7", "half 2", {16'b0, d1}, {16'b0, w[28:13]});
      chk(d2 == exp_up(w), "R4/R7", "half 1", {16'b0, d2}, {16'b0, exp_up(w)});
    end else begin
      chk(d1 == exp_up(w), "R4/R7", "half 1", {16'b0, d1}, {16'b0, exp_up(w)});
      chk(d2 == w[28:13], "R7", "half 2", {16'b0, d2}, {16'b0, w[28:13]});
    end
  endtask

  task automatic drain();
    logic [15:0] d;
    if (!ready_n) begin rd(0, d); rd(1, d); end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] w, a;
    logic [15:0] d;
    repeat (3) @(negedge clk);
    chk(ready_n == 1, "R5", "reset ready_n", {31'b0, ready_n}, 1);
    rst_n = 1;
    idle(40);

    // R2 R4 R7: sweep of words, alternating read order
    for (int i = 0; i < 20; i++) begin
      w = (i * 32'h9E3779B1) ^ (32'(i) << 7) ^ 32'h0F0F_1234;
      if (i == 0) w = 32'h0;
      if (i == 1) w = 32'hFFFF_FFFF;
      if (i == 2) w = 32'h0000_0001;
      send(w, 5, 5, 0, 0, -1, 40);
      take_word(w, i[0], "R2");
    end

    // R3: label screen, every setting against every label value
    label_chk_en = 1;
    for (int m = 0; m < 4; m++)
      for (int l = 0; l < 4; l++) begin
        label_bits = m[1:0];
        w = 32'hA5C3_1E69 + 32'(m * 977 + l * 131);
        w[9:8] = l[1:0];
        send(w, 5, 5, 0, 0, -1, 40);
        chk(ready_n == (m != l), "R3", "label accept", {31'b0, ready_n}, {31'b0, m != l});
        if (m == l) take_word(w, 0, "R3");
        drain();
      end
    label_chk_en = 0;

    // R9: tolerance edges accepted
    w = 32'h3C5A_9617;
    send(w, 4, 6, 0, 0, -1, 40);  take_word(w, 1, "R9");
    send(~w, 6, 4, 0, 0, -1, 40); take_word(~w, 0, "R9");

    // R9: each malformed shape discards the word, then a clean one recovers
    for (int k = 1; k <= 5; k++) begin
      send(32'h1357_9BDF ^ 32'(k), 5, 5, k, 12, -1, 40);
      chk(ready_n == 1, "R9", "malformed word rejected", {31'b0, ready_n}, 1);
    end
    send(w, 5, 5, 0, 0, -1, 40); take_word(w, 0, "R9");

    // R8: overwrite without read
    a = 32'h1111_2222; w = 32'h8765_4321;
    send(a, 5, 5, 0, 0, -1, 40);
    send(w, 5, 5, 0, 0, -1, 40);
    take_word(w, 1, "R8");

    // R8: read colliding with store is void
    send(a, 5, 5, 0, 0, -1, 40);
    send(w ^ 32'h00F0_0F00, 5, 5, 0, 0, 1, 40);
    chk(ready_n == 0, "R8", "ready after collision", {31'b0, ready_n}, 0);
    rd(0, d);
    chk(ready_n == 0, "R8", "collided read voided", {31'b0, ready_n}, 0);
    chk(d == exp_up(w ^ 32'h00F0_0F00), "R8", "new word held", {16'b0, d}, {16'b0, exp_up(w ^ 32'h00F0_0F00)});
    rd(1, d);
    chk(ready_n == 1, "R8", "release after both", {31'b0, ready_n}, 1);

    // R10: partial word aborted by long null, next word clean
    for (int i = 0; i < 10; i++) begin
      for (int j = 0; j < 5; j++) put(1, 0);
      idle(5);
    end
    idle(32);
    chk(ready_n == 1, "R10", "partial not stored", {31'b0, ready_n}, 1);
    send(w, 5, 5, 0, 0, -1, 40); take_word(w, 0, "R10");

    // R10: word starting without a gap is ignored
    send(a, 5, 5, 0, 0, -1, 10);
    send(w, 5, 5, 0, 0, -1, 40);
    take_word(a, 1, "R10");

    // R1: slow rate
    rate_slow = 1; div = 8;
    idle(40);
    w = 32'hC0DE_5EED;
    send(w, 5, 5, 0, 0, -1, 40); take_word(w, 0, "R1");
    div = 1;
    send(~w, 5, 5, 0, 0, -1, 40);
    chk(ready_n == 1, "R1", "fast stimulus at slow rate", {31'b0, ready_n}, 1);
    div = 8; idle(40);
    rate_slow = 0; div = 1; idle(40);

    // R11: loopback
    loopback_en = 1; lb = 1; idle(40);
    w = 32'h7E57_0B0B;
    send(w, 5, 5, 0, 0, -1, 40); take_word(w, 1, "R11");
    lb = 0;
    send(w, 5, 5, 0, 0, -1, 40);
    chk(ready_n == 1, "R11", "line ignored in loopback", {31'b0, ready_n}, 1);
    loopback_en = 0; idle(40);
    lb = 1;
    send(~w, 5, 5, 0, 0, -1, 40);
    chk(ready_n == 1, "R11", "tx wires ignored in normal mode", {31'b0, ready_n}, 1);
    lb = 0; idle(40);
    send(~w, 5, 5, 0, 0, -1, 40); take_word(~w, 0, "R11");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule